// File: doc/BRIEF.md
# Mode-Selectable Delay and Pulse Timer

This block is a clocked timer with three selectable behaviours chosen by a 2-bit mode input: a one-shot pulse that cannot be retriggered, an on-delay that reports an input only once it has stayed high long enough, and an off-delay that keeps its output high for a while after the input drops. Time is measured in ticks. A tick is a one-cycle enable strobe from a shared prescaler, so the same block serves microsecond and second time bases without changing width.

The programmed duration `preset` and the elapsed count `elapsed` are unsigned tick counts, `CNT_W` bits wide. All outputs are registered. A change on `in_lvl` or `mode` sampled at a clock edge shows on `q` and `elapsed` right after that same edge. The block has no data stream, so every pin is a plain control or status level and there is no valid/ready handshake or back-pressure. The mode is meant to stay constant while the timer runs. Any change of mode returns the timer to idle.

Top module: `mode_timer`

## Requirements
- R1: Pulse mode (mode = 0): a rising edge of `in_lvl` while idle sets `q` and starts `elapsed` at 0. Each tick then adds one until `elapsed` equals `preset`. On the next edge the pulse ends.
- R2: In pulse mode, toggling `in_lvl` while a pulse runs neither restarts nor shortens it. `q` stays high and `elapsed` keeps counting.
- R3: When a pulse ends, `q` takes the level `in_lvl` has at that edge. If it is high, `q` stays high until `in_lvl` is sampled low, and that held level does not start a new pulse.
- R4: On-delay mode (mode = 1): while `in_lvl` is high, ticks advance `elapsed`. `q` goes high at the edge after `elapsed` reaches `preset` and stays high while `in_lvl` stays high.
- R5: In on-delay mode, `in_lvl` sampled low clears `q` and `elapsed` at that edge, even when it is released before the delay expires.
- R6: Off-delay mode (mode = 2): `in_lvl` sampled high sets `q`. After `in_lvl` drops, ticks advance `elapsed`. Once `elapsed` has reached `preset`, the next edge clears `q`.
- R7: In off-delay mode, `in_lvl` sampled high again during the off-delay clears `elapsed` and keeps `q` high.
- R8: `elapsed` moves only by +1 on an edge where `tick` is high, or back to 0. It never counts past `preset`.
- R9: With `preset` = 0, on-delay `q` follows `in_lvl` one edge later. A one-cycle input pulse gives a one-cycle `q` in pulse mode and in off-delay mode.
- R10: Reset clears `q` and `elapsed`. `elapsed` reads 0 whenever the timer is idle.
- R11: A change of `mode` clears `q` and `elapsed` at the edge where it is sampled. Mode 3 disables the timer, holding `q` and `elapsed` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_lvl | input | 1 | Timer input level |
| preset | input | CNT_W | Programmed duration in ticks |
| tick | input | 1 | One-cycle time-base strobe |
| mode | input | 2 | 0 pulse, 1 on-delay, 2 off-delay, 3 disabled |
| q | output | 1 | Timer output |
| elapsed | output | CNT_W | Elapsed ticks of the current timing run |

## Verification
The bench toggles the input during a running pulse. A design that retriggers would restart `elapsed` at zero, and one that stops early would drop `q` before `preset`. It releases the input just before the on-delay expires and reasserts it during the off-delay. A design that failed to clear would raise `q` too soon, or fail to keep it high. It also runs `preset` = 0 in every mode, sparse ticks against a saturating count, and a mode switch in mid-run. An off-by-one there would show as a two-cycle pulse, as a count past the preset, or as a stale output after the switch.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_PULSE  = 2'd0,
    MODE_ONDLY  = 2'd1,
    MODE_OFFDLY = 2'd2,
    MODE_OFF    = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sig;
  end
  assign rise = sig & ~prev;
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             reached
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign reached = (count >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (clr)                   count <= '0;
    else if (en && tick && !reached) count <= count + ONE;
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  tmr_mode_e mode,
  input  logic      in_lvl,
  input  logic      rise,
  input  logic      reached,
  output logic      q,
  output logic      clr,
  output logic      cnt_en
);
  tmr_mode_e mode_q;
  logic      run, run_n, q_n;

  always_comb begin
    clr    = 1'b0;
    cnt_en = 1'b0;
    run_n  = 1'b0;
    q_n    = 1'b0;
    if (mode != mode_q) begin
      clr = 1'b1;
    end else begin
      case (mode)
        MODE_PULSE: begin
          if (run) begin
            if (reached) begin
              q_n = in_lvl;
              clr = 1'b1;
            end else begin
              run_n  = 1'b1;
              q_n    = 1'b1;
              cnt_en = 1'b1;
            end
          end else begin
            clr = 1'b1;
            if (rise) begin
              run_n = 1'b1;
              q_n   = 1'b1;
            end else begin
              q_n = q & in_lvl;
            end
          end
        end
        MODE_ONDLY: begin
          if (!in_lvl) begin
            clr = 1'b1;
          end else begin
            cnt_en = 1'b1;
            q_n    = reached;
          end
        end
        MODE_OFFDLY: begin
          if (in_lvl) begin
            q_n = 1'b1;
            clr = 1'b1;
          end else if (q && !reached) begin
            q_n    = 1'b1;
            cnt_en = 1'b1;
          end else begin
            clr = 1'b1;
          end
        end
        default: clr = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_PULSE;
      run    <= 1'b0;
      q      <= 1'b0;
    end else begin
      mode_q <= mode;
      run    <= run_n;
      q      <= q_n;
    end
  end
endmodule

// File: rtl/mode_timer.sv
module mode_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_lvl,
  input  logic [CNT_W-1:0] preset,
  input  logic             tick,
  input  logic [1:0]       mode,
  output logic             q,
  output logic [CNT_W-1:0] elapsed
);
  logic rise, reached, clr, cnt_en;

  tmr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sig(in_lvl), .rise(rise)
  );

  tmr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(tmr_mode_e'(mode)), .in_lvl(in_lvl),
    .rise(rise), .reached(reached), .q(q), .clr(clr), .cnt_en(cnt_en)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(cnt_en), .tick(tick),
    .limit(preset), .count(elapsed), .reached(reached)
  );
endmodule

// File: rtl/mode_timer_chk.sv
module mode_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_lvl,
  input logic             tick,
  input logic [1:0]       mode,
  input logic             q,
  input logic [CNT_W-1:0] elapsed
);
  // R8
  et_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed != $past(elapsed)) |-> (elapsed == '0 || elapsed == $past(elapsed) + CNT_W'(1)));
  // R8
  et_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed != '0 && elapsed != $past(elapsed)) |-> $past(tick));
  // R1
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd0 && $rose(q)) |-> (elapsed == '0));
  // R5
  ondly_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd1 && !$past(in_lvl)) |-> (!q && elapsed == '0));
  // R7
  offdly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd2 && $past(in_lvl)) |-> (elapsed == '0));
  // R11
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd3) |-> (!q && elapsed == '0));
endmodule

bind mode_timer mode_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_lvl(in_lvl), .tick(tick),
  .mode(mode), .q(q), .elapsed(elapsed)
);

// File: tb/mode_timer_test.sv
module mode_timer_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_lvl = 1'b0;
  logic [W-1:0] preset = '0;
  logic         tick = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic         q;
  logic [W-1:0] elapsed;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int watchdog = 0;

  always #10 clk = ~clk;

  mode_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_lvl(in_lvl), .preset(preset),
    .tick(tick), .mode(mode), .q(q), .elapsed(elapsed)
  );

  typedef struct {
    logic         q;
    logic [W-1:0] et;
    string        tag;
  } exp_t;
  exp_t sb[$];

  // model of the requirements
  logic         mq = 1'b0, mrun = 1'b0, mprev = 1'b0;
  logic [W-1:0] met = '0;
  logic [1:0]   mmode = 2'd0;

  task automatic step(input logic i, input logic t, input logic [1:0] m,
                      input logic [W-1:0] p, input string tag);
    logic nq, nrun, done;
    logic [W-1:0] net;
    exp_t e;
    @(negedge clk);
    in_lvl = i; tick = t; mode = m; preset = p;
    done = (met >= p);
    nq = 1'b0; nrun = 1'b0; net = '0;
    if (m == mmode) begin
      if (m == 2'd0) begin
        if (mrun && done) nq = i;
        else if (mrun) begin nq = 1'b1; nrun = 1'b1; net = t ? met + 1'b1 : met; end
        else if (i && !mprev) begin nq = 1'b1; nrun = 1'b1; end
        else nq = mq & i;
      end else if (m == 2'd1) begin
        if (i) begin nq = done; net = (t && !done) ? met + 1'b1 : met; end
      end else if (m == 2'd2) begin
        if (i) nq = 1'b1;
        else if (mq && !done) begin nq = 1'b1; net = t ? met + 1'b1 : met; end
      end
    end
    mq = nq; met = net; mrun = nrun; mprev = i; mmode = m;
    e.q = nq; e.et = net; e.tag = tag;
    sb.push_back(e);
  endtask

  // n cycles at level v; tick every div cycles
  task automatic hold(input logic v, input int n, input int div, input logic [1:0] m,
                      input logic [W-1:0] p, input string tag);
    for (int k = 0; k < n; k++) begin
      step(v, (cyc % div) == 0, m, p, tag);
      cyc++;
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        compared++;
        if (q !== e.q || elapsed !== e.et) begin
          mismatched++;
          $display("FAIL %s: q=%0b elapsed=%0d expected q=%0b elapsed=%0d",
                   e.tag, q, elapsed, e.q, e.et);
        end
      end
    end
  end

  always @(posedge clk) begin
    watchdog++;
    if (watchdog > 20000) begin
      mismatched++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", watchdog);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (q !== 1'b0 || elapsed !== '0) begin
      mismatched++;
      $display("FAIL R10 reset: q=%0b elapsed=%0d expected q=0 elapsed=0", q, elapsed);
    end
    rst_n = 1'b1;

    // R1 basic pulse, short input
    hold(1, 1, 1, 2'd0, 8'd3, "R1");
    hold(0, 8, 1, 2'd0, 8'd3, "R1");
    // R2 toggling during pulse
    for (int k = 0; k < 5; k++) begin
      hold(1, 1, 1, 2'd0, 8'd6, "R2");
      hold(0, 1, 1, 2'd0, 8'd6, "R2");
    end
    hold(0, 4, 1, 2'd0, 8'd6, "R2");
    // R3 input held past expiry
    hold(1, 8, 1, 2'd0, 8'd2, "R3");
    hold(0, 3, 1, 2'd0, 8'd2, "R3");
    // R4 on-delay
    hold(1, 8, 1, 2'd1, 8'd3, "R4");
    hold(0, 3, 1, 2'd1, 8'd3, "R4");
    // R5 early release
    hold(1, 3, 1, 2'd1, 8'd5, "R5");
    hold(0, 2, 1, 2'd1, 8'd5, "R5");
    hold(1, 9, 1, 2'd1, 8'd5, "R5");
    hold(0, 2, 1, 2'd1, 8'd5, "R5");
    // R6 off-delay
    hold(1, 2, 1, 2'd2, 8'd3, "R6");
    hold(0, 8, 1, 2'd2, 8'd3, "R6");
    // R7 reassertion during off-delay
    hold(1, 2, 1, 2'd2, 8'd4, "R7");
    hold(0, 2, 1, 2'd2, 8'd4, "R7");
    hold(1, 1, 1, 2'd2, 8'd4, "R7");
    hold(0, 9, 1, 2'd2, 8'd4, "R7");
    // R8 sparse ticks, saturation
    hold(1, 18, 3, 2'd1, 8'd4, "R8");
    hold(0, 2, 3, 2'd1, 8'd4, "R8");
    hold(1, 1, 2, 2'd0, 8'd3, "R8");
    hold(0, 10, 2, 2'd0, 8'd3, "R8");
    // R9 zero preset in each mode
    hold(1, 3, 1, 2'd1, 8'd0, "R9");
    hold(0, 2, 1, 2'd1, 8'd0, "R9");
    hold(1, 1, 1, 2'd2, 8'd0, "R9");
    hold(0, 3, 1, 2'd2, 8'd0, "R9");
    hold(0, 1, 1, 2'd0, 8'd0, "R9");
    hold(1, 1, 1, 2'd0, 8'd0, "R9");
    hold(0, 3, 1, 2'd0, 8'd0, "R9");
    // R10 idle after activity
    hold(0, 4, 1, 2'd1, 8'd7, "R10");
    // R11 mode change mid-run, disabled mode
    hold(1, 2, 1, 2'd2, 8'd9, "R11");
    hold(0, 3, 1, 2'd2, 8'd9, "R11");
    hold(0, 2, 1, 2'd0, 8'd9, "R11");
    hold(1, 2, 1, 2'd1, 8'd1, "R11");
    hold(1, 2, 1, 2'd3, 8'd1, "R11");
    hold(0, 2, 1, 2'd3, 8'd1, "R11");
    hold(1, 2, 1, 2'd3, 8'd1, "R11");
    hold(1, 3, 1, 2'd1, 8'd1, "R11");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule